// File: doc/BRIEF.md
# Extended Configuration Register File

This block holds the 512-byte extended configuration array of a managed flash card and carries out the byte update requested by a SWITCH command. The command decoder upstream hands over the 32-bit command argument with a one-cycle strobe, plus a level that says whether the card sits in the transfer state. The block decodes the argument and changes at most one byte of the writable lower 192 bytes. It then holds a busy level that the response path uses to drive the busy-type response. It also reports a switch-error flag in the card status word.

The upper 320 bytes describe the card and never change. They are produced from parameters: capacity in sectors, boot partition size, and a set of fixed revision and performance bytes. A byte-wide read port with one cycle of latency lets the data-line serializer stream all 512 bytes out as one data block. Command framing, CRC and the serializer itself sit outside this block.

Top module: `xcfg_regfile`

## Requirements
- R1: The argument is decoded as access mode = bits [25:24], byte index = bits [23:16], value = bits [15:8] and command-set field = bits [2:0]. The command-set field and all other bits have no effect on the array.
- R2: Access mode 1 ORs the value into the addressed byte.
- R3: Access mode 2 clears in the addressed byte every bit that is set in the value.
- R4: Access mode 3 replaces the addressed byte with the value.
- R5: Access mode 0 (command-set change) is accepted but leaves every byte unchanged.
- R6: An accepted SWITCH whose index is 192 or above changes no byte and sets bit 7 of `stat_flags`, the card status word. Every other bit of `stat_flags` is always zero. The index check takes priority over the access mode. The next accepted SWITCH with an index below 192 clears the bit.
- R7: A strobe is accepted only while `in_transfer` is high and `busy` is low. Any other strobe is ignored: no byte, `busy` or `stat_flags` changes.
- R8: After an accepted strobe, `busy` is high for exactly BUSY_CYCLES clock cycles, starting in the cycle after the strobe, and then falls.
- R9: After reset, byte 179 (partition configuration) holds BOOT_CFG, bytes 0 to 191 otherwise hold zero, and `busy` and `stat_flags` are zero.
- R10: `rd_data` shows the byte at `rd_addr` one clock cycle after `rd_addr` is presented, for any address 0 to 511.
- R11: Bytes 212 to 215 hold CAPACITY_SECTORS little-endian, with the least significant byte at 212.
- R12: Byte 226 holds BOOT_BYTES / 131072. The other read-only bytes are fixed:
  - byte 192 = 3
  - byte 194 = 2
  - byte 196 = 3
  - bytes 205 to 210 = 0x46
  - byte 504 = 1
  - every other byte from 192 to 511 = 0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_transfer | input | 1 | Card is in the transfer state |
| sw_valid | input | 1 | One-cycle SWITCH strobe |
| sw_arg | input | 32 | SWITCH command argument |
| rd_addr | input | 9 | Byte address for the read port |
| rd_data | output | 8 | Byte read, valid one cycle after the address |
| busy | output | 1 | Programming in progress, drives the busy response |
| stat_flags | output | 32 | Card status contribution; bit 7 is the switch error |

## Verification
The byte update and the switch-error bit both take effect at the clock edge that samples the strobe. `busy` rises at that same edge and stays high for BUSY_CYCLES edges. A read returns its byte one edge after the address is driven.

The bench drives inputs and samples outputs on falling edges. It checks `busy` and `stat_flags` on the first falling edge after the accepting edge, then counts `busy` falling edge by falling edge until it drops. It reads a byte back only after `busy` has fallen, comparing it against the array model of the bench on the next falling edge.

// File: rtl/xcfg_pkg.sv
package xcfg_pkg;

    localparam int XC_BYTES      = 512;
    localparam int XC_MODE_BYTES = 192;
    localparam int XC_AW         = $clog2(XC_BYTES);

    // byte positions a host decodes
    localparam int PART_CFG_IDX  = 179;
    localparam int REV_IDX       = 192;
    localparam int STRUCT_IDX    = 194;
    localparam int CARD_TYPE_IDX = 196;
    localparam int PERF_LO_IDX   = 205;
    localparam int PERF_HI_IDX   = 210;
    localparam int SEC_CNT_IDX   = 212;
    localparam int BOOT_MULT_IDX = 226;
    localparam int CMDSET_IDX    = 504;
    localparam int BOOT_UNIT     = 131072;

    typedef enum logic [1:0] {
        ACC_CSET = 2'd0,
        ACC_SET  = 2'd1,
        ACC_CLR  = 2'd2,
        ACC_WR   = 2'd3
    } acc_e;

    typedef struct packed {
        acc_e       mode;
        logic [7:0] idx;
        logic [7:0] val;
        logic [2:0] cset;
    } sw_cmd_t;

    typedef enum logic {
        PH_XFER = 1'b0,
        PH_PROG = 1'b1
    } phase_e;

    function automatic logic [7:0] apply_acc(input acc_e m, input logic [7:0] old,
                                             input logic [7:0] v);
        logic [7:0] r;
        case (m)
            ACC_SET: r = old | v;
            ACC_CLR: r = old & ~v;
            ACC_WR:  r = v;
            default: r = old;
        endcase
        return r;
    endfunction

    function automatic logic [7:0] prop_byte(input logic [XC_AW-1:0] a,
                                             input logic [31:0] sec,
                                             input logic [7:0] bmult);
        logic [7:0] b;
        b = 8'h00;
        if (a >= XC_AW'(PERF_LO_IDX) && a <= XC_AW'(PERF_HI_IDX))
            b = 8'h46;
        case (a)
            XC_AW'(SEC_CNT_IDX):     b = sec[7:0];
            XC_AW'(SEC_CNT_IDX + 1): b = sec[15:8];
            XC_AW'(SEC_CNT_IDX + 2): b = sec[23:16];
            XC_AW'(SEC_CNT_IDX + 3): b = sec[31:24];
            XC_AW'(BOOT_MULT_IDX):   b = bmult;
            XC_AW'(REV_IDX):         b = 8'd3;
            XC_AW'(STRUCT_IDX):      b = 8'd2;
            XC_AW'(CARD_TYPE_IDX):   b = 8'd3;
            XC_AW'(CMDSET_IDX):      b = 8'd1;
            default: ;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/xcfg_decode.sv
module xcfg_decode
    import xcfg_pkg::*;
(
    input  logic [31:0] arg,
    output sw_cmd_t     cmd,
    output logic        idx_ro
);
    always_comb begin
        cmd.mode = acc_e'(arg[25:24]);
        cmd.idx  = arg[23:16];
        cmd.val  = arg[15:8];
        cmd.cset = arg[2:0];
    end

    assign idx_ro = (arg[23:16] >= 8'(XC_MODE_BYTES));
endmodule

// File: rtl/xcfg_modes.sv
module xcfg_modes
    import xcfg_pkg::*;
#(
    parameter logic [7:0] BOOT_CFG = 8'h00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  sw_cmd_t    wr_cmd,
    input  logic [7:0] rd_idx,
    output logic [7:0] rd_byte
);
    localparam int FLAT_W = XC_MODE_BYTES * 8;

    logic [FLAT_W-1:0] flat;

    for (genvar g = 0; g < XC_MODE_BYTES; g++) begin : g_byte
        localparam logic [7:0] RST_VAL = (g == PART_CFG_IDX) ? BOOT_CFG : 8'h00;
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= RST_VAL;
            else if (wr_en && wr_cmd.idx == 8'(g))
                q <= apply_acc(wr_cmd.mode, q, wr_cmd.val);
        end
        assign flat[g*8 +: 8] = q;
    end

    always_comb begin
        rd_byte = 8'h00;
        if (rd_idx < 8'(XC_MODE_BYTES))
            rd_byte = flat[32'(rd_idx)*8 +: 8];
    end

    // R6
    // no_ro_write_chk
    no_ro_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_cmd.idx < 8'(XC_MODE_BYTES)));

    // R9
    // part_cfg_hold_chk
    part_cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || wr_cmd.idx != 8'(PART_CFG_IDX)) |=>
            $stable(flat[PART_CFG_IDX*8 +: 8]));
endmodule

// File: rtl/xcfg_props.sv
module xcfg_props
    import xcfg_pkg::*;
#(
    parameter logic [31:0] CAPACITY_SECTORS = 32'h0074_0000,
    parameter int          BOOT_BYTES       = 524288
) (
    input  logic [XC_AW-1:0] addr,
    output logic [7:0]       data
);
    localparam logic [7:0] BMULT = 8'(BOOT_BYTES / BOOT_UNIT);

    assign data = prop_byte(addr, CAPACITY_SECTORS, BMULT);
endmodule

// File: rtl/xcfg_ctrl.sv
module xcfg_ctrl
    import xcfg_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sw_valid,
    input  logic in_transfer,
    input  logic idx_ro,
    output logic accept,
    output logic busy,
    output logic sw_error
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;

    assign accept = sw_valid && in_transfer && (phase_q == PH_XFER);
    assign busy   = (phase_q == PH_PROG);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_XFER;
            cnt_q    <= '0;
            sw_error <= 1'b0;
        end else begin
            case (phase_q)
                PH_XFER: if (accept) begin
                    phase_q  <= PH_PROG;
                    cnt_q    <= CW'(BUSY_CYCLES - 1);
                    sw_error <= idx_ro;
                end
                PH_PROG: begin
                    if (cnt_q == '0)
                        phase_q <= PH_XFER;
                    else
                        cnt_q <= cnt_q - 1'b1;
                end
                default: phase_q <= PH_XFER;
            endcase
        end
    end

    // checker counter: length of the current busy run
    logic [CW:0] run_q;
    always_ff @(posedge clk) begin
        if (rst)       run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    // R8
    // busy_len_chk
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_q < (CW+1)'(BUSY_CYCLES)));

    // R8
    // busy_start_chk
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);

    // R7
    // busy_cause_chk
    busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(sw_valid && in_transfer));

    // R6
    // err_cause_chk
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sw_error) |-> $past(idx_ro && accept));
endmodule

// File: rtl/xcfg_regfile.sv
module xcfg_regfile
    import xcfg_pkg::*;
#(
    parameter logic [31:0] CAPACITY_SECTORS = 32'h0074_0000,
    parameter int          BOOT_BYTES       = 524288,
    parameter logic [7:0]  BOOT_CFG         = 8'h00,
    parameter int          BUSY_CYCLES      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_transfer,
    input  logic             sw_valid,
    input  logic [31:0]      sw_arg,
    input  logic [XC_AW-1:0] rd_addr,
    output logic [7:0]       rd_data,
    output logic             busy,
    output logic [31:0]      stat_flags
);
    sw_cmd_t    cmd;
    logic       idx_ro;
    logic       accept;
    logic       sw_error;
    logic [7:0] mode_rd;
    logic [7:0] prop_rd;

    xcfg_decode u_dec (
        .arg    (sw_arg),
        .cmd    (cmd),
        .idx_ro (idx_ro)
    );

    xcfg_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .sw_valid    (sw_valid),
        .in_transfer (in_transfer),
        .idx_ro      (idx_ro),
        .accept      (accept),
        .busy        (busy),
        .sw_error    (sw_error)
    );

    xcfg_modes #(.BOOT_CFG(BOOT_CFG)) u_modes (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (accept && !idx_ro),
        .wr_cmd  (cmd),
        .rd_idx  (rd_addr[7:0]),
        .rd_byte (mode_rd)
    );

    xcfg_props #(
        .CAPACITY_SECTORS(CAPACITY_SECTORS),
        .BOOT_BYTES      (BOOT_BYTES)
    ) u_props (
        .addr (rd_addr),
        .data (prop_rd)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= 8'h00;
        else
            rd_data <= (rd_addr < XC_AW'(XC_MODE_BYTES)) ? mode_rd : prop_rd;
    end

    assign stat_flags = {24'h0, sw_error, 7'h0};

    // R7
    // idle_status_chk
    idle_status_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(sw_valid && in_transfer)) |=> $stable(stat_flags));
endmodule

// File: tb/xcfg_regfile_tb.sv
module xcfg_regfile_tb;
    localparam int          CLK_PERIOD = 10;
    localparam int          BUSY_N     = 3;
    localparam logic [31:0] CAP        = 32'h0012_3456;
    localparam int          BOOTB      = 262144;
    localparam logic [7:0]  BCFG       = 8'h5A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_transfer = 1'b1;
    logic        sw_valid = 1'b0;
    logic [31:0] sw_arg = '0;
    logic [8:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        busy;
    logic [31:0] stat_flags;

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_mem [512];

    always #(CLK_PERIOD/2) clk = ~clk;

    xcfg_regfile #(
        .CAPACITY_SECTORS(CAP),
        .BOOT_BYTES      (BOOTB),
        .BOOT_CFG        (BCFG),
        .BUSY_CYCLES     (BUSY_N)
    ) u_dut (
        .clk(clk), .rst(rst), .in_transfer(in_transfer), .sw_valid(sw_valid),
        .sw_arg(sw_arg), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
        .stat_flags(stat_flags)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    task automatic read_chk(input int a, input string req);
        rd_addr = 9'(a);
        @(negedge clk);
        chk(rd_data == exp_mem[a], req, int'(rd_data), int'(exp_mem[a]));
    endtask

    function automatic logic [31:0] mk_arg(input int mode, input int idx, input int val);
        // junk in unused bits and command-set field (R1)
        return {6'(idx * 5), 2'(mode), 8'(idx), 8'(val), 5'(idx >> 1), 3'(idx)};
    endfunction

    // accepted switch: checks status and the busy window
    task automatic do_switch(input int mode, input int idx, input int val, input string req);
        logic [7:0] cur;
        bit err;
        err = (idx >= 192);
        if (!err) begin
            cur = exp_mem[idx];
            case (mode)
                1: cur = cur | 8'(val);
                2: cur = cur & ~8'(val);
                3: cur = 8'(val);
                default: ;
            endcase
            exp_mem[idx] = cur;
        end
        sw_arg = mk_arg(mode, idx, val);
        sw_valid = 1'b1;
        @(negedge clk);
        sw_valid = 1'b0;
        chk(stat_flags == (err ? 32'h80 : 32'h0), "R6 status bit 7", int'(stat_flags),
            err ? 32'h80 : 0);
        for (int i = 1; i <= BUSY_N; i++) begin
            chk(busy == 1'b1, "R8 busy high", int'(busy), 1);
            @(negedge clk);
        end
        chk(busy == 1'b0, "R8 busy low after window", int'(busy), 0);
        if (!err) read_chk(idx, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // expected reset image from R9, R11, R12
        for (int a = 0; a < 512; a++) exp_mem[a] = 8'h00;
        exp_mem[179] = BCFG;
        exp_mem[192] = 8'd3;
        exp_mem[194] = 8'd2;
        exp_mem[196] = 8'd3;
        for (int a = 205; a <= 210; a++) exp_mem[a] = 8'h46;
        exp_mem[212] = CAP[7:0];
        exp_mem[213] = CAP[15:8];
        exp_mem[214] = CAP[23:16];
        exp_mem[215] = CAP[31:24];
        exp_mem[226] = 8'(BOOTB / 131072);
        exp_mem[504] = 8'd1;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R9 busy at reset", int'(busy), 0);
        chk(stat_flags == 32'h0, "R9 status at reset", int'(stat_flags), 0);
        // full reset image, R9 R10 R11 R12
        for (int a = 0; a < 512; a++) read_chk(a, "R10 R9 R11 R12 reset image");

        // sweep every writable byte through all four access modes
        for (int i = 0; i < 192; i++) begin
            do_switch(3, i, (i * 37 + 11) & 8'hFF, "R4 write byte");
            do_switch(1, i, 8'hA5 ^ i, "R2 set bits");
            do_switch(2, i, (8'h3C + i) & 8'hFF, "R3 clear bits");
            do_switch(0, i, 8'hFF, "R5 command set ignored");
        end

        // read-only indexes: error, no change; then legal clears error (R6)
        for (int i = 192; i < 256; i += 7) do_switch(3, i, 8'hEE, "R6 ro index");
        do_switch(0, 5, 8'h00, "R6 legal clears error");
        chk(stat_flags == 32'h0, "R6 error cleared", int'(stat_flags), 0);

        // R7: strobe outside transfer state is ignored
        in_transfer = 1'b0;
        sw_arg = mk_arg(3, 17, 8'h99);
        sw_valid = 1'b1;
        @(negedge clk);
        sw_valid = 1'b0;
        in_transfer = 1'b1;
        chk(busy == 1'b0, "R7 no busy when not in transfer", int'(busy), 0);
        read_chk(17, "R7 byte kept when not in transfer");

        // R7: strobe while busy is ignored
        do_switch(3, 40, 8'h12, "R4 write before busy test");
        sw_arg = mk_arg(3, 40, 8'h77);
        sw_valid = 1'b1;
        @(negedge clk);
        sw_valid = 1'b0;
        @(negedge clk);
        sw_arg = mk_arg(3, 41, 8'h66);
        sw_valid = 1'b1;
        @(negedge clk);
        sw_valid = 1'b0;
        exp_mem[40] = 8'h77;
        repeat (BUSY_N + 2) @(negedge clk);
        chk(busy == 1'b0, "R8 busy dropped", int'(busy), 0);
        read_chk(40, "R4 accepted write");
        read_chk(41, "R7 byte kept when strobed during busy");

        // final full readback, R10
        for (int a = 0; a < 512; a++) read_chk(a, "R10 final image");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule